// File: doc/BRIEF.md
# Inflight Packet Credit Release

This block keeps two sets of inflight packet counters: one reference count per bucket, held in a bucket status table, and one count per notification ring. The ingress side raises an increment strobe that names a bucket and a ring, and each of those two counters goes up by one. Software returns credits with a memory-mapped store. The store address names a bucket, a ring and a service domain index, and carries one enable bit for each table. The low 16 bits of the store data give how many packets are being returned.

A single store can reduce the bucket counter, the ring counter, or both. Each table is gated by its own enable bit in the address. A counter never goes below zero. A release that asks for more than the counter holds leaves the counter at zero and raises a sticky underflow flag. The bucket status table also has an index/data port. Software uses it to initialise an entry's assigned ring, reference count, group and mode, and to read an entry back.

When a release is accepted, the block reports its service domain index one cycle later. Downstream permission logic uses that index to address its own 32-entry table.

Top module: `credit_release`

## Requirements
- R1: After reset, every bucket entry reads 0, every ring count reads 0, and underflow_o and rel_valid_o are 0.
- R2: A store is a release only when mmio_wr_i is 1 and address bits [28:26] equal 4. A store with any other value in that field changes no counter and does not raise rel_valid_o.
- R3: In a release with bucket-enable (address bit 25) set, the count field of the entry named by address bits [23:11] drops by mmio_wdata_i. The entry's ring, group and mode fields are unchanged. With bit 25 clear, no bucket changes.
- R4: In a release with ring-enable (address bit 24) set, the count of the ring named by address bits [10:3] drops by mmio_wdata_i. With bit 24 clear, no ring changes. Both counters may drop in the same store.
- R5: A decrement larger than the current value leaves the counter at 0 and sets underflow_o. underflow_o then stays 1 until reset.
- R6: When inc_i is 1, bucket inc_bkt_i and ring inc_ring_i each rise by one at the next edge. A counter at 0xFFFF stays at 0xFFFF.
- R7: An increment and a release that hit the same counter in the same cycle are both applied. The result is old + 1 - count, saturated at 0.
- R8: tbl_wdata_i layout: ring [7:0], count [23:8], group [28:24], mode [31:29]. tbl_rdata_o shows entry tbl_idx_i combinationally. A write with tbl_wr_i stores tbl_wdata_i at the next edge and overrides any increment or release to that entry in the same cycle. An overridden release does not set underflow_o.
- R9: One cycle after a release is accepted, rel_valid_o is 1 and rel_svc_o holds address bits [39:35] of that store.
- R10: A bucket index at or above NUM_BUCKETS, or a ring index at or above NUM_RINGS, in a release or an increment changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mmio_wr_i | input | 1 | Memory-mapped store strobe |
| mmio_addr_i | input | 40 | Store address (ring, bucket, enables, region, service domain) |
| mmio_wdata_i | input | 16 | Release count |
| inc_i | input | 1 | Ingress increment strobe |
| inc_bkt_i | input | 13 | Bucket to increment |
| inc_ring_i | input | 8 | Ring to increment |
| tbl_wr_i | input | 1 | Bucket table write strobe |
| tbl_idx_i | input | $clog2(NUM_BUCKETS) | Bucket table read/write index |
| tbl_wdata_i | input | 32 | Bucket entry to write |
| tbl_rdata_o | output | 32 | Bucket entry at tbl_idx_i |
| ring_idx_i | input | $clog2(NUM_RINGS) | Ring count read index |
| ring_cnt_o | output | 16 | Count of ring ring_idx_i |
| underflow_o | output | 1 | Sticky underflow flag |
| rel_valid_o | output | 1 | A release was accepted in the previous cycle |
| rel_svc_o | output | 5 | Service domain index of that release |

## Verification
A release and an ingress increment can reach the same bucket or ring counter in the same cycle. A table write can also land on an entry that a release or an increment targets in that cycle. Directed cases drive each of these collisions at a chosen count, including one that would underflow. Random traffic then confines indices to a few entries, so such collisions recur often. The bench judges every cycle against a reference model. That model applies the increment and the decrement together with saturation, and gives a table write priority over both.

// File: rtl/crd_pkg.sv
package crd_pkg;
  localparam int ADDR_W      = 40;
  localparam int CNT_W       = 16;
  localparam int RING_LSB    = 3;
  localparam int RING_W      = 8;
  localparam int BKT_LSB     = 11;
  localparam int BKT_W       = 13;
  localparam int RING_EN_BIT = 24;
  localparam int BKT_EN_BIT  = 25;
  localparam int REGION_LSB  = 26;
  localparam int REGION_W    = 3;
  localparam int SVC_LSB     = 35;
  localparam int SVC_W       = 5;
  localparam logic [REGION_W-1:0] REL_REGION = 3'd4;

  typedef struct packed {
    logic [2:0]       mode;
    logic [4:0]       group;
    logic [CNT_W-1:0] count;
    logic [7:0]       ring;
  } bkt_entry_t;

  typedef struct packed {
    logic              valid;
    logic              ring_en;
    logic              bkt_en;
    logic [RING_W-1:0] ring;
    logic [BKT_W-1:0]  bkt;
    logic [SVC_W-1:0]  svc;
    logic [CNT_W-1:0]  amt;
  } rel_req_t;

  // returns {underflow, new value}; saturates both ways
  function automatic logic [CNT_W:0] sat_upd(logic [CNT_W-1:0] old_v, logic inc,
                                             logic [CNT_W-1:0] amt);
    logic [CNT_W+1:0] sum;
    logic [CNT_W+1:0] diff;
    sum = {2'b00, old_v} + {{(CNT_W+1){1'b0}}, inc};
    if (sum < {2'b00, amt}) begin
      sat_upd = {1'b1, {CNT_W{1'b0}}};
    end else begin
      diff = sum - {2'b00, amt};
      if (diff[CNT_W]) sat_upd = {1'b0, {CNT_W{1'b1}}};
      else             sat_upd = {1'b0, diff[CNT_W-1:0]};
    end
  endfunction
endpackage

// File: rtl/crd_decode.sv
module crd_decode
  import crd_pkg::*;
(
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  data_i,
  output rel_req_t          req_o
);
  logic unused_addr;
  assign unused_addr = ^{addr_i[RING_LSB-1:0], addr_i[SVC_LSB-1:REGION_LSB+REGION_W]};

  always_comb begin
    req_o         = '0;
    req_o.valid   = wr_i && (addr_i[REGION_LSB +: REGION_W] == REL_REGION);
    req_o.ring_en = addr_i[RING_EN_BIT];
    req_o.bkt_en  = addr_i[BKT_EN_BIT];
    req_o.ring    = addr_i[RING_LSB +: RING_W];
    req_o.bkt     = addr_i[BKT_LSB +: BKT_W];
    req_o.svc     = addr_i[SVC_LSB +: SVC_W];
    req_o.amt     = data_i;
  end
endmodule

// File: rtl/crd_bkt_tbl.sv
module crd_bkt_tbl
  import crd_pkg::*;
#(
  parameter int NUM_BUCKETS = 64,
  localparam int IW = $clog2(NUM_BUCKETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [BKT_W-1:0] inc_idx_i,
  input  rel_req_t         req_i,
  input  logic             wr_i,
  input  logic [IW-1:0]    idx_i,
  input  bkt_entry_t       wdata_i,
  output bkt_entry_t       rdata_o,
  output logic             uf_o
);
  bkt_entry_t       ent_w [NUM_BUCKETS];
  logic [NUM_BUCKETS-1:0] uf_vec;

  for (genvar g = 0; g < NUM_BUCKETS; g++) begin : g_ent
    bkt_entry_t     ent_q;
    logic           hit_inc, hit_rel, hit_wr;
    logic [CNT_W:0] upd;

    assign hit_inc   = inc_i && (inc_idx_i == BKT_W'(g));
    assign hit_rel   = req_i.valid && req_i.bkt_en && (req_i.bkt == BKT_W'(g));
    assign hit_wr    = wr_i && (idx_i == IW'(g));
    assign upd       = sat_upd(ent_q.count, hit_inc, hit_rel ? req_i.amt : '0);
    assign uf_vec[g] = upd[CNT_W] && !hit_wr;
    assign ent_w[g]  = ent_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q <= '0;
      else if (hit_wr) ent_q <= wdata_i;
      else             ent_q.count <= upd[CNT_W-1:0];
    end
  end

  assign rdata_o = ent_w[idx_i];
  assign uf_o    = |uf_vec;
endmodule

// File: rtl/crd_ring_tbl.sv
module crd_ring_tbl
  import crd_pkg::*;
#(
  parameter int NUM_RINGS = 32,
  localparam int RIW = $clog2(NUM_RINGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic [RING_W-1:0] inc_idx_i,
  input  rel_req_t          req_i,
  input  logic [RIW-1:0]    rd_idx_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              uf_o
);
  logic [CNT_W-1:0]     cnt_w [NUM_RINGS];
  logic [NUM_RINGS-1:0] uf_vec;

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    logic [CNT_W-1:0] cnt_q;
    logic             hit_inc, hit_rel;
    logic [CNT_W:0]   upd;

    assign hit_inc   = inc_i && (inc_idx_i == RING_W'(g));
    assign hit_rel   = req_i.valid && req_i.ring_en && (req_i.ring == RING_W'(g));
    assign upd       = sat_upd(cnt_q, hit_inc, hit_rel ? req_i.amt : '0);
    assign uf_vec[g] = upd[CNT_W];
    assign cnt_w[g]  = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= upd[CNT_W-1:0];
    end
  end

  assign cnt_o = cnt_w[rd_idx_i];
  assign uf_o  = |uf_vec;
endmodule

// File: rtl/credit_release.sv
module credit_release
  import crd_pkg::*;
#(
  parameter int NUM_BUCKETS = 64,
  parameter int NUM_RINGS   = 32,
  localparam int IW  = $clog2(NUM_BUCKETS),
  localparam int RIW = $clog2(NUM_RINGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mmio_wr_i,
  input  logic [ADDR_W-1:0] mmio_addr_i,
  input  logic [CNT_W-1:0]  mmio_wdata_i,
  input  logic              inc_i,
  input  logic [BKT_W-1:0]  inc_bkt_i,
  input  logic [RING_W-1:0] inc_ring_i,
  input  logic              tbl_wr_i,
  input  logic [IW-1:0]     tbl_idx_i,
  input  logic [31:0]       tbl_wdata_i,
  output logic [31:0]       tbl_rdata_o,
  input  logic [RIW-1:0]    ring_idx_i,
  output logic [CNT_W-1:0]  ring_cnt_o,
  output logic              underflow_o,
  output logic              rel_valid_o,
  output logic [SVC_W-1:0]  rel_svc_o
);
  rel_req_t   req;
  bkt_entry_t bkt_rd;
  logic       bkt_uf, ring_uf;

  crd_decode u_dec (
    .wr_i  (mmio_wr_i),
    .addr_i(mmio_addr_i),
    .data_i(mmio_wdata_i),
    .req_o (req)
  );

  crd_bkt_tbl #(.NUM_BUCKETS(NUM_BUCKETS)) u_bkt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc_i),
    .inc_idx_i(inc_bkt_i),
    .req_i    (req),
    .wr_i     (tbl_wr_i),
    .idx_i    (tbl_idx_i),
    .wdata_i  (bkt_entry_t'(tbl_wdata_i)),
    .rdata_o  (bkt_rd),
    .uf_o     (bkt_uf)
  );

  crd_ring_tbl #(.NUM_RINGS(NUM_RINGS)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc_i),
    .inc_idx_i(inc_ring_i),
    .req_i    (req),
    .rd_idx_i (ring_idx_i),
    .cnt_o    (ring_cnt_o),
    .uf_o     (ring_uf)
  );

  assign tbl_rdata_o = 32'(bkt_rd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      underflow_o <= 1'b0;
      rel_valid_o <= 1'b0;
      rel_svc_o   <= '0;
    end else begin
      underflow_o <= underflow_o | bkt_uf | ring_uf;
      rel_valid_o <= req.valid;
      if (req.valid) rel_svc_o <= req.svc;
    end
  end
endmodule

// File: rtl/credit_release_chk.sv
module credit_release_chk #(
  parameter int IW  = 6,
  parameter int RIW = 5
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mmio_wr_i,
  input logic [39:0] mmio_addr_i,
  input logic        inc_i,
  input logic        tbl_wr_i,
  input logic [IW-1:0]  tbl_idx_i,
  input logic [31:0] tbl_wdata_i,
  input logic [31:0] tbl_rdata_o,
  input logic [RIW-1:0] ring_idx_i,
  input logic [15:0] ring_cnt_o,
  input logic        underflow_o,
  input logic        rel_valid_o,
  input logic [4:0]  rel_svc_o
);
  // R5
  underflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |=> underflow_o);

  // R2
  non_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_wr_i && mmio_addr_i[28:26] != 3'd4) |=> !rel_valid_o);

  // R9
  rel_report_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mmio_wr_i && mmio_addr_i[28:26] == 3'd4) |=>
      (rel_valid_o && rel_svc_o == $past(mmio_addr_i[39:35])));

  // R8
  tbl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_i |=> ((tbl_idx_i != $past(tbl_idx_i)) || (tbl_rdata_o == $past(tbl_wdata_i))));

  // R4
  ring_no_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(inc_i) && $stable(ring_idx_i)) |-> (ring_cnt_o <= $past(ring_cnt_o)));
endmodule

bind credit_release credit_release_chk #(.IW(IW), .RIW(RIW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mmio_wr_i  (mmio_wr_i),
  .mmio_addr_i(mmio_addr_i),
  .inc_i      (inc_i),
  .tbl_wr_i   (tbl_wr_i),
  .tbl_idx_i  (tbl_idx_i),
  .tbl_wdata_i(tbl_wdata_i),
  .tbl_rdata_o(tbl_rdata_o),
  .ring_idx_i (ring_idx_i),
  .ring_cnt_o (ring_cnt_o),
  .underflow_o(underflow_o),
  .rel_valid_o(rel_valid_o),
  .rel_svc_o  (rel_svc_o)
);

// File: tb/credit_release_tb_top.sv
`timescale 1ns/1ps
module credit_release_tb_top;
  localparam int NB = 64;
  localparam int NR = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mmio_wr_i = 1'b0;
  logic [39:0] mmio_addr_i = '0;
  logic [15:0] mmio_wdata_i = '0;
  logic        inc_i = 1'b0;
  logic [12:0] inc_bkt_i = '0;
  logic [7:0]  inc_ring_i = '0;
  logic        tbl_wr_i = 1'b0;
  logic [5:0]  tbl_idx_i = '0;
  logic [31:0] tbl_wdata_i = '0;
  logic [31:0] tbl_rdata_o;
  logic [4:0]  ring_idx_i = '0;
  logic [15:0] ring_cnt_o;
  logic        underflow_o;
  logic        rel_valid_o;
  logic [4:0]  rel_svc_o;

  credit_release #(.NUM_BUCKETS(NB), .NUM_RINGS(NR)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  logic [31:0] bm [NB];
  logic [15:0] rm [NR];
  logic        uf_m = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] mk_addr(int region, int svc, int ring, int bkt, bit ren, bit ben);
    logic [39:0] a = '0;
    a[10:3]  = ring[7:0];
    a[23:11] = bkt[12:0];
    a[24]    = ren;
    a[25]    = ben;
    a[28:26] = region[2:0];
    a[39:35] = svc[4:0];
    return a;
  endfunction

  function automatic logic [15:0] sat(logic [15:0] old_v, bit inc, logic [15:0] amt, inout logic uf);
    int v = int'(old_v) + int'(inc) - int'(amt);
    if (v < 0) begin uf = 1'b1; v = 0; end
    if (v > 65535) v = 65535;
    return v[15:0];
  endfunction

  task automatic clr();
    mmio_wr_i = 0; inc_i = 0; tbl_wr_i = 0; mmio_wdata_i = '0;
  endtask

  // apply one cycle, update model, check outputs 1 ns after the edge
  task automatic tick(string tag);
    bit rel, exp_rv;
    logic [4:0] exp_svc;
    logic [15:0] amt;
    rel = mmio_wr_i && mmio_addr_i[28:26] == 3'd4;
    exp_rv = rel;
    exp_svc = mmio_addr_i[39:35];
    amt = mmio_wdata_i;
    @(posedge clk_i);
    for (int b = 0; b < NB; b++) begin
      bit hi = inc_i && inc_bkt_i == 13'(b);
      bit hr = rel && mmio_addr_i[25] && mmio_addr_i[23:11] == 13'(b);
      logic ufl = 1'b0;
      logic [15:0] nv = sat(bm[b][23:8], hi, hr ? amt : 16'd0, ufl);
      if (tbl_wr_i && tbl_idx_i == 6'(b)) bm[b] = tbl_wdata_i;
      else begin bm[b][23:8] = nv; uf_m = uf_m | ufl; end
    end
    for (int r = 0; r < NR; r++) begin
      bit hi = inc_i && inc_ring_i == 8'(r);
      bit hr = rel && mmio_addr_i[24] && mmio_addr_i[10:3] == 8'(r);
      logic ufl = 1'b0;
      rm[r] = sat(rm[r], hi, hr ? amt : 16'd0, ufl);
      uf_m = uf_m | ufl;
    end
    #1;
    chk(tag, tbl_rdata_o, bm[tbl_idx_i]);
    chk(tag, 32'(ring_cnt_o), 32'(rm[ring_idx_i]));
    chk(tag, 32'(underflow_o), 32'(uf_m));
    chk(tag, 32'(rel_valid_o), 32'(exp_rv));
    if (exp_rv) chk(tag, 32'(rel_svc_o), 32'(exp_svc));
    @(negedge clk_i);
    clr();
  endtask

  task automatic see(string tag, int b, int r);
    tbl_idx_i = 6'(b); ring_idx_i = 5'(r);
    #1;
    chk(tag, tbl_rdata_o, bm[b]);
    chk(tag, 32'(ring_cnt_o), 32'(rm[r]));
  endtask

  task automatic release_op(int svc, int ring, int bkt, bit ren, bit ben, int amt, int region = 4);
    mmio_wr_i = 1; mmio_addr_i = mk_addr(region, svc, ring, bkt, ren, ben);
    mmio_wdata_i = 16'(amt);
  endtask

  task automatic twrite(int b, logic [31:0] d);
    tbl_wr_i = 1; tbl_idx_i = 6'(b); tbl_wdata_i = d;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) bm[b] = '0;
    for (int r = 0; r < NR; r++) rm[r] = '0;
    #45 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    see("R1", 0, 0); see("R1", 63, 31);
    chk("R1", 32'(underflow_o), 0);
    chk("R1", 32'(rel_valid_o), 0);

    // R8 init entry 5: mode 2, group 7, count 10, ring 3
    twrite(5, {3'd2, 5'd7, 16'd10, 8'd3}); ring_idx_i = 3; tick("R8");
    // R6 three increments
    for (int i = 0; i < 3; i++) begin
      inc_i = 1; inc_bkt_i = 5; inc_ring_i = 3; tbl_idx_i = 5; ring_idx_i = 3; tick("R6");
    end
    // R3 bucket only, amount 4
    release_op(9, 3, 5, 0, 1, 4); tick("R3");
    // R4 ring only, amount 1
    release_op(2, 3, 5, 1, 0, 1); tick("R4");
    // R4 both in one store, amount 2
    release_op(17, 3, 5, 1, 1, 2); tick("R4");
    // R2 wrong region
    release_op(1, 3, 5, 1, 1, 1, 3); tick("R2");
    release_op(1, 3, 5, 1, 1, 1, 6); tick("R2");
    // R7 increment and release same counters
    inc_i = 1; inc_bkt_i = 5; inc_ring_i = 3; release_op(30, 3, 5, 1, 1, 1); tick("R7");
    // R8 write overrides inc and an underflowing release
    inc_i = 1; inc_bkt_i = 5; release_op(4, 0, 5, 0, 1, 500);
    twrite(5, {3'd1, 5'd2, 16'd20, 8'd9}); tick("R8");
    // R10 out-of-range indices leave aliases untouched
    twrite(36, {3'd0, 5'd0, 16'd50, 8'd0}); tick("R10");
    tbl_idx_i = 36; ring_idx_i = 8;
    release_op(3, 40, 100, 1, 1, 7); tick("R10");
    inc_i = 1; inc_bkt_i = 100; inc_ring_i = 40; tbl_idx_i = 36; ring_idx_i = 8; tick("R10");
    // R6 saturation at max
    twrite(7, {3'd0, 5'd0, 16'hFFFF, 8'd0}); tick("R6");
    inc_i = 1; inc_bkt_i = 7; tbl_idx_i = 7; tick("R6");
    // R5 underflow saturates and sticks
    release_op(5, 3, 5, 1, 1, 100); tbl_idx_i = 5; ring_idx_i = 3; tick("R5");
    tick("R5");

    // random traffic on a few entries
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) begin
        inc_i = 1; inc_bkt_i = 13'($urandom_range(0, 3)); inc_ring_i = 8'($urandom_range(0, 3));
      end
      if (op >= 2 && op < 8)
        release_op($urandom_range(0, 31), $urandom_range(0, 3), $urandom_range(0, 3),
                   1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                   ($urandom_range(0, 7) == 0) ? 2 : 4);
      if (op == 9) twrite($urandom_range(0, 3), $urandom);
      if (!tbl_wr_i) tbl_idx_i = 6'($urandom_range(0, 3));
      ring_idx_i = 5'($urandom_range(0, 3));
      tick("R7");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule